// File: doc/BRIEF.md
# Flash program and erase sequencer

This block sits on the host side of a byte-wide flash part that takes its commands through an internal command register. It runs two algorithms without processor help. The first writes one byte with retries. The second is a full-chip erase with retries. It talks to the flash through a simple request/acknowledge bus on which each transfer is either a command write or a verify read. It times the program and erase pulses with a cycle counter, and it compares every verify read with the value it expects.

A program run starts from `prog_start` with an address and a byte. An erase run starts from `erase_start`. Erase has three phases. It first programs every byte of the array to 00h, walking the addresses upward. It then pulses the erase. Last, it verifies each byte against FFh from address 0 upward. When a byte does not verify, the sequencer erases the whole chip again and continues checking at that same byte. Both runs end with a read-mode command written to the flash, followed by a one-cycle `done` or `fail`. On failure, `fail_addr` holds the address that could not be verified.

Top module: `flash_seq`

## Requirements
- R1: A program attempt issues four bus transfers in this order: a write of 40h, a write of the target byte at the target address, a write of C0h, and a read at the target address. `bus_we`=1 marks a write and `bus_we`=0 marks a read.
- R2: After the write of the target byte is acknowledged, the next bus request is raised no sooner than PROG_PULSE clock cycles later.
- R3: If the verify read differs from the target byte, the attempt is repeated. After PROG_TRIES attempts that all differ, the run ends with `fail`, and `fail_addr` holds the target address. The attempt count restarts for every byte.
- R4: An erase run first programs every address from 0 to DEPTH-1, in ascending order, to 00h. Each byte uses the R1–R3 attempt scheme. This phase finishes before the first erase command is written.
- R5: An erase pulse is two consecutive writes of 20h. The next request comes no sooner than ERASE_PULSE cycles after the second write is acknowledged. Each byte is then checked by a write of A0h at its address followed by a read, which must return FFh. A passing byte advances the address by one. The run succeeds after address DEPTH-1 passes.
- R6: When an erase-verify read returns anything other than FFh, a new erase pulse is issued and verification resumes at the address that failed.
- R7: The erase pulse count covers the whole erase run. When a verify fails after ERASE_TRIES pulses have been issued, the run ends with `fail`, and `fail_addr` holds the failing address.
- R8: Every run, whether it passes or fails, writes 00h as its last bus transfer before `done` or `fail` is raised.
- R9: `busy` rises the cycle after a start is accepted and stays high until the cycle in which `done` or `fail` pulses for exactly one cycle. The two never pulse together. Start inputs are ignored while `busy` is high.
- R10: While `bus_req` is high and `bus_ack` is low, the request and its `bus_we`, `bus_addr` and `bus_wdata` hold their values.
- R11: After reset, `busy`, `done`, `fail` and `bus_req` are all low.
- R12: When `prog_start` and `erase_start` are both high in the same idle cycle, the program run is the one that executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_start | input | 1 | Start a single-byte program run |
| prog_addr | input | ADDR_W | Target address of the program run |
| prog_data | input | 8 | Byte to program |
| erase_start | input | 1 | Start a full-chip erase run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: run succeeded |
| fail | output | 1 | One-cycle pulse: run abandoned |
| fail_addr | output | ADDR_W | Address that failed to verify |
| bus_req | output | 1 | Flash bus transfer request |
| bus_we | output | 1 | 1 = command write, 0 = verify read |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | 8 | Write data or command code |
| bus_ack | input | 1 | Transfer accepted or read data valid |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |

## Verification
A wrong internal state shows first on the bus. A misordered sequencer state puts a wrong command code or address on `bus_wdata` or `bus_addr` at the next request. A timer that expires early raises `bus_req` sooner than the pulse time after a pulse-starting write. A stale retry or erase counter changes the number of pulse-starting writes before `fail`, which shows within one attempt of the limit. A lost resume address shows as an A0h write at the wrong address in the first verify after an erase pulse.

// File: rtl/flash_seq_pkg.sv
// Package: shared state type and flash command codes for the sequencer.
// Assumes a byte-wide flash with an internal command register.
package flash_seq_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_READ_MODE  = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_PROG_SETUP = 8'h40;
    localparam logic [BYTE_W-1:0] CMD_PROG_CHECK = 8'hC0;
    localparam logic [BYTE_W-1:0] CMD_ERASE      = 8'h20;
    localparam logic [BYTE_W-1:0] CMD_ERASE_CHK  = 8'hA0;
    localparam logic [BYTE_W-1:0] BYTE_BLANK     = 8'hFF;
    localparam logic [BYTE_W-1:0] BYTE_ZERO      = 8'h00;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PSETUP,
        S_PDATA,
        S_PWAIT,
        S_PVCMD,
        S_PVREAD,
        S_ESETUP,
        S_EGO,
        S_EWAIT,
        S_EVCMD,
        S_EVREAD,
        S_EXIT
    } seq_state_t;

    // True for states that perform exactly one bus transfer.
    function automatic logic is_bus_state(seq_state_t s);
        return (s != S_IDLE) && (s != S_PWAIT) && (s != S_EWAIT);
    endfunction

endpackage

// File: rtl/flash_bus_port.sv
// Module: flash_bus_port
// Holds a single request/acknowledge transfer on the flash bus.
// Assumes op_start arrives only while no transfer is outstanding; the
// fields are registered on op_start and held until bus_ack is seen.
module flash_bus_port #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_we,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              op_done,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack
);

    // Launch a transfer, then hold it until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (op_start) begin
            bus_req   <= 1'b1;
            bus_we    <= op_we;
            bus_addr  <= op_addr;
            bus_wdata <= op_wdata;
        end else if (bus_req && bus_ack) begin
            bus_req   <= 1'b0;
        end
    end

    // The transfer completes in the cycle the acknowledge meets the request.
    assign op_done = bus_req & bus_ack;

endmodule

// File: rtl/flash_pulse_timer.sv
// Module: flash_pulse_timer
// Down-counter that measures a program or erase pulse in clock cycles.
// Assumes load is a single-cycle pulse; expired is low while loading.
module flash_pulse_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Load the pulse length, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Report the end of the pulse once the count has drained.
    assign expired = !load && (cnt == '0);

endmodule

// File: rtl/flash_try_counter.sv
// Module: flash_try_counter
// Attempt counter with a synchronous clear that wins over the increment.
// Assumes the caller checks the limit, so the count never wraps in use.
module flash_try_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    // Count attempts; clear restarts the count for a new byte or run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/flash_seq.sv
// Module: flash_seq (top)
// Runs the byte-program algorithm and the full-chip erase algorithm on a
// flash command interface: command writes and verify reads over a
// request/acknowledge bus, pulse timing, read-back comparison and retries.
// Assumes the flash answers each request with bus_ack and, for reads,
// valid bus_rdata in the same cycle.
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int DEPTH       = 32768,
    parameter int PROG_PULSE  = 500,
    parameter int ERASE_PULSE = 500000,
    parameter int PROG_TRIES  = 25,
    parameter int ERASE_TRIES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_start,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              erase_start,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata
);

    localparam int PULSE_MAX = (ERASE_PULSE > PROG_PULSE) ? ERASE_PULSE : PROG_PULSE;
    localparam int TW  = $clog2(PULSE_MAX + 1);
    localparam int PCW = $clog2(PROG_TRIES + 1);
    localparam int ECW = $clog2(ERASE_TRIES + 1);
    localparam logic [TW-1:0]     PROG_LEN  = TW'(PROG_PULSE);
    localparam logic [TW-1:0]     ERASE_LEN = TW'(ERASE_PULSE);
    localparam logic [PCW-1:0]    PROG_LIM  = PCW'(PROG_TRIES);
    localparam logic [ECW-1:0]    ERASE_LIM = ECW'(ERASE_TRIES);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] ADDR_ONE  = ADDR_W'(1);

    seq_state_t        state, state_n;
    logic              launch;
    logic [ADDR_W-1:0] cur_addr, addr_n;
    logic [7:0]        cur_data, data_n;
    logic              erase_mode, mode_n;
    logic              ok_q, ok_n;
    logic [ADDR_W-1:0] fail_addr_q, faddr_n;
    logic              clr_prog, clr_erase;
    logic              done_q, fail_q;

    logic              op_start, op_we, op_done;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_wdata;
    logic              tmr_load, pulse_over;
    logic [TW-1:0]     tmr_val;
    logic [PCW-1:0]    prog_tries;
    logic [ECW-1:0]    erase_tries;

    flash_bus_port #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .op_start(op_start), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
        .op_done(op_done),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack)
    );

    flash_pulse_timer #(.CNT_W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .expired(pulse_over)
    );

    flash_try_counter #(.CNT_W(PCW)) u_prog_cnt (
        .clk(clk), .rst_n(rst_n),
        .clear(clr_prog), .inc(launch && (state == S_PDATA)), .count(prog_tries)
    );

    flash_try_counter #(.CNT_W(ECW)) u_erase_cnt (
        .clk(clk), .rst_n(rst_n),
        .clear(clr_erase), .inc(launch && (state == S_EGO)), .count(erase_tries)
    );

    // Pick the single bus transfer belonging to the current state.
    always_comb begin
        op_we    = 1'b1;
        op_addr  = cur_addr;
        op_wdata = CMD_READ_MODE;
        unique case (state)
            S_PSETUP: op_wdata = CMD_PROG_SETUP;
            S_PDATA:  op_wdata = cur_data;
            S_PVCMD:  op_wdata = CMD_PROG_CHECK;
            S_PVREAD: op_we    = 1'b0;
            S_ESETUP: op_wdata = CMD_ERASE;
            S_EGO:    op_wdata = CMD_ERASE;
            S_EVCMD:  op_wdata = CMD_ERASE_CHK;
            S_EVREAD: op_we    = 1'b0;
            default:  op_wdata = CMD_READ_MODE;
        endcase
    end

    // Launch a transfer or load the timer in the first cycle of a state.
    always_comb begin
        op_start = launch && is_bus_state(state);
        tmr_load = launch && ((state == S_PWAIT) || (state == S_EWAIT));
        tmr_val  = (state == S_EWAIT) ? ERASE_LEN : PROG_LEN;
    end

    // Next-state logic for both algorithms.
    always_comb begin
        state_n   = state;
        addr_n    = cur_addr;
        data_n    = cur_data;
        mode_n    = erase_mode;
        ok_n      = ok_q;
        faddr_n   = fail_addr_q;
        clr_prog  = 1'b0;
        clr_erase = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (prog_start) begin
                    state_n  = S_PSETUP;
                    addr_n   = prog_addr;
                    data_n   = prog_data;
                    mode_n   = 1'b0;
                    clr_prog = 1'b1;
                end else if (erase_start) begin
                    state_n   = S_PSETUP;
                    addr_n    = '0;
                    data_n    = BYTE_ZERO;
                    mode_n    = 1'b1;
                    clr_prog  = 1'b1;
                    clr_erase = 1'b1;
                end
            end
            S_PSETUP: if (op_done) state_n = S_PDATA;
            S_PDATA:  if (op_done) state_n = S_PWAIT;
            S_PWAIT:  if (pulse_over) state_n = S_PVCMD;
            S_PVCMD:  if (op_done) state_n = S_PVREAD;
            S_PVREAD: begin
                if (op_done) begin
                    if (bus_rdata == cur_data) begin
                        if (!erase_mode) begin
                            ok_n    = 1'b1;
                            state_n = S_EXIT;
                        end else if (cur_addr == LAST_ADDR) begin
                            addr_n  = '0;
                            state_n = S_ESETUP;
                        end else begin
                            addr_n   = cur_addr + ADDR_ONE;
                            clr_prog = 1'b1;
                            state_n  = S_PSETUP;
                        end
                    end else if (prog_tries >= PROG_LIM) begin
                        ok_n    = 1'b0;
                        faddr_n = cur_addr;
                        state_n = S_EXIT;
                    end else begin
                        state_n = S_PSETUP;
                    end
                end
            end
            S_ESETUP: if (op_done) state_n = S_EGO;
            S_EGO:    if (op_done) state_n = S_EWAIT;
            S_EWAIT:  if (pulse_over) state_n = S_EVCMD;
            S_EVCMD:  if (op_done) state_n = S_EVREAD;
            S_EVREAD: begin
                if (op_done) begin
                    if (bus_rdata == BYTE_BLANK) begin
                        if (cur_addr == LAST_ADDR) begin
                            ok_n    = 1'b1;
                            state_n = S_EXIT;
                        end else begin
                            addr_n  = cur_addr + ADDR_ONE;
                            state_n = S_EVCMD;
                        end
                    end else if (erase_tries >= ERASE_LIM) begin
                        ok_n    = 1'b0;
                        faddr_n = cur_addr;
                        state_n = S_EXIT;
                    end else begin
                        state_n = S_ESETUP;
                    end
                end
            end
            S_EXIT:   if (op_done) state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            launch      <= 1'b0;
            cur_addr    <= '0;
            cur_data    <= '0;
            erase_mode  <= 1'b0;
            ok_q        <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            state       <= state_n;
            launch      <= (state_n != state) && (state_n != S_IDLE);
            cur_addr    <= addr_n;
            cur_data    <= data_n;
            erase_mode  <= mode_n;
            ok_q        <= ok_n;
            fail_addr_q <= faddr_n;
        end
    end

    // One-cycle result pulses, raised as the final read-mode write completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= (state == S_EXIT) && op_done && ok_q;
            fail_q <= (state == S_EXIT) && op_done && !ok_q;
        end
    end

    assign busy      = (state != S_IDLE);
    assign done      = done_q;
    assign fail      = fail_q;
    assign fail_addr = fail_addr_q;

endmodule

// File: rtl/flash_seq_checker.sv
// Module: flash_seq_checker
// Port-level properties of flash_seq, attached through bind. Pulse
// windows are measured with a local counter so large pulse lengths
// are never unrolled.
module flash_seq_checker #(
    parameter int ADDR_W      = 15,
    parameter int PROG_PULSE  = 500,
    parameter int ERASE_PULSE = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_ack
);

    localparam int GAP_CAP = 1 << 30;

    logic       hs_w;
    logic       req_d, p_setup, e_half, gap_armed, gap_erase;
    logic [7:0] last_wd;
    int         gap;

    assign hs_w = bus_req && bus_ack && bus_we;

    // Track the command history and the cycles since a pulse began.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d     <= 1'b0;
            p_setup   <= 1'b0;
            e_half    <= 1'b0;
            gap_armed <= 1'b0;
            gap_erase <= 1'b0;
            last_wd   <= 8'hFF;
            gap       <= 0;
        end else begin
            req_d <= bus_req;
            if (gap < GAP_CAP) gap <= gap + 1;
            if (bus_req && !req_d) gap_armed <= 1'b0;
            if (hs_w) begin
                last_wd <= bus_wdata;
                if (p_setup) begin
                    p_setup   <= 1'b0;
                    e_half    <= 1'b0;
                    gap_armed <= 1'b1;
                    gap_erase <= 1'b0;
                    gap       <= 0;
                end else if (bus_wdata == 8'h40) begin
                    p_setup <= 1'b1;
                    e_half  <= 1'b0;
                end else if (bus_wdata == 8'h20) begin
                    if (e_half) begin
                        e_half    <= 1'b0;
                        gap_armed <= 1'b1;
                        gap_erase <= 1'b1;
                        gap       <= 0;
                    end else begin
                        e_half <= 1'b1;
                    end
                end else begin
                    e_half <= 1'b0;
                end
            end
        end
    end

    // R10: an unacknowledged request keeps its fields.
    assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)))
        else $error("bus request changed before acknowledge");

    // R9: results are exclusive single-cycle pulses with busy low.
    assert_result_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fail}))
        else $error("done and fail together");

    assert_result_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |=> !(done || fail))
        else $error("result held longer than one cycle");

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || fail))
        else $error("busy dropped without a result");

    // R11: no bus activity while idle.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req)
        else $error("bus request while idle");

    // R8: the last write before a result is the read-mode command.
    assert_exit_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> (last_wd == 8'h00))
        else $error("result without read-mode write");

    // R2 and R5: no request inside the pulse window.
    assert_pulse_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !req_d && gap_armed && !gap_erase) |-> (gap >= PROG_PULSE))
        else $error("program pulse cut short");

    assert_pulse_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !req_d && gap_armed && gap_erase) |-> (gap >= ERASE_PULSE))
        else $error("erase pulse cut short");

endmodule

bind flash_seq flash_seq_checker #(
    .ADDR_W(ADDR_W),
    .PROG_PULSE(PROG_PULSE),
    .ERASE_PULSE(ERASE_PULSE)
) u_chk (.*);

// File: tb/sim_flash_seq.sv
// Bench for flash_seq: a behavioural flash model with injectable program
// and erase resistance, a transfer log, a program-vector table and
// directed erase and control tests.
module sim_flash_seq;

    localparam int AW = 3;
    localparam int DEPTH = 8;
    localparam int PP = 6;
    localparam int EP = 20;
    localparam int PT = 4;
    localparam int ET = 5;
    localparam int LOGN = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_start = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [7:0]    prog_data = '0;
    logic          erase_start = 1'b0;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_ack = 1'b0;
    logic [7:0]    bus_rdata = '0;

    flash_seq #(
        .ADDR_W(AW), .DEPTH(DEPTH), .PROG_PULSE(PP), .ERASE_PULSE(EP),
        .PROG_TRIES(PT), .ERASE_TRIES(ET)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_start(erase_start), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- flash model ----------------
    localparam int M_CMD = 0, M_PDATA = 1, M_PV = 2, M_E1 = 3, M_EV = 4;
    logic [7:0] mem [DEPTH];
    int mode = M_CMD;
    int resist = 0;
    int weak_addr = 0;
    int weak_left = 0;
    int pv_addr = 0;
    int ev_addr = 0;
    int erase_pulses = 0;
    int pre_ok = 1;
    int ack_delay = 0;
    int wait_cnt = 0;
    int hold_err = 0;
    int done_cnt = 0;
    logic          f_we;
    logic [AW-1:0] f_addr;
    logic [7:0]    f_wd;
    logic          c_we;
    logic [AW-1:0] c_addr;
    logic [7:0]    c_wd;
    int            f_cyc;

    logic          lg_we   [LOGN];
    logic [AW-1:0] lg_addr [LOGN];
    logic [7:0]    lg_dat  [LOGN];
    int            lg_req  [LOGN];
    int            lg_ack  [LOGN];
    int            lg_n = 0;

    task automatic do_erase_pulse();
        erase_pulses++;
        if (erase_pulses == 1)
            for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'h00) pre_ok = 0;
        for (int i = 0; i < DEPTH; i++)
            if (!(i == weak_addr && weak_left > 0)) mem[i] = 8'hFF;
        if (weak_left > 0) weak_left--;
    endtask

    task automatic apply_write(input logic [AW-1:0] a, input logic [7:0] d);
        if (mode == M_PDATA) begin
            if (resist > 0) resist--;
            else mem[a] = mem[a] & d;
            pv_addr = int'(a);
            mode = M_CMD;
        end else if (d == 8'h40) mode = M_PDATA;
        else if (d == 8'hC0) mode = M_PV;
        else if (d == 8'h20) begin
            if (mode == M_E1) begin do_erase_pulse(); mode = M_CMD; end
            else mode = M_E1;
        end else if (d == 8'hA0) begin mode = M_EV; ev_addr = int'(a); end
        else mode = M_CMD;
    endtask

    // Answer requests on the falling edge after ack_delay cycles.
    always @(negedge clk) begin
        if (done) done_cnt++;
        if (bus_ack) begin
            bus_ack = 1'b0;
            wait_cnt = 0;
            if (c_we) apply_write(c_addr, c_wd);
        end else if (bus_req) begin
            if (wait_cnt == 0) begin
                f_we = bus_we; f_addr = bus_addr; f_wd = bus_wdata; f_cyc = cyc;
            end
            if (wait_cnt >= ack_delay) begin
                if (bus_we != f_we || bus_addr != f_addr || bus_wdata != f_wd) hold_err++;
                c_we = bus_we; c_addr = bus_addr; c_wd = bus_wdata;
                if (mode == M_PV) bus_rdata = mem[pv_addr];
                else if (mode == M_EV) bus_rdata = mem[ev_addr];
                else bus_rdata = mem[bus_addr];
                if (lg_n < LOGN) begin
                    lg_we[lg_n] = bus_we; lg_addr[lg_n] = bus_addr;
                    lg_dat[lg_n] = bus_we ? bus_wdata : bus_rdata;
                    lg_req[lg_n] = f_cyc; lg_ack[lg_n] = cyc;
                    lg_n++;
                end
                bus_ack = 1'b1;
            end else wait_cnt++;
        end
    end

    // ---------------- helpers ----------------
    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic prep(input int dly);
        lg_n = 0; erase_pulses = 0; pre_ok = 1; mode = M_CMD;
        resist = 0; weak_left = 0; ack_delay = dly; done_cnt = 0;
    endtask

    task automatic wait_end(output bit got_done, output bit got_fail);
        got_done = 0; got_fail = 0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (done || fail) begin got_done = done; got_fail = fail; break; end
        end
    endtask

    function automatic bit is_pdata(input int k);
        return (k > 0) && lg_we[k] && lg_we[k-1] && (lg_dat[k-1] == 8'h40);
    endfunction

    function automatic int count_cmd(input logic [7:0] c);
        int n = 0;
        for (int k = 0; k < lg_n; k++) if (lg_we[k] && lg_dat[k] == c && !is_pdata(k)) n++;
        return n;
    endfunction

    // ---------------- program vector table ----------------
    typedef struct packed {
        logic [2:0] addr;
        logic [7:0] data;
        logic [7:0] init;
        logic [3:0] resist;
        logic       exp_fail;
        logic [3:0] exp_tries;
    } pvec_t;

    localparam pvec_t PVECS [5] = '{
        '{3'd3, 8'hA5, 8'hFF, 4'd0, 1'b0, 4'd1},
        '{3'd7, 8'h00, 8'hFF, 4'd2, 1'b0, 4'd3},
        '{3'd0, 8'h3C, 8'hFF, 4'd3, 1'b0, 4'd4},
        '{3'd5, 8'hF0, 8'hFF, 4'd4, 1'b1, 4'd4},
        '{3'd2, 8'h81, 8'h0F, 4'd0, 1'b1, 4'd4}
    };

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit gd, gf;
        int n, first_pd, ordered, pulse_idx, first_a0_after;
        int resume_addr [3];
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        // R11: reset state
        check_eq("R11 busy", int'(busy), 0);
        check_eq("R11 done/fail", int'(done | fail), 0);
        check_eq("R11 bus_req", int'(bus_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R11 idle after release", int'(busy | bus_req), 0);

        // Program vectors walked by one loop (R1, R2, R3, R8).
        for (int v = 0; v < 5; v++) begin
            prep(v % 3);
            for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
            mem[PVECS[v].addr] = PVECS[v].init;
            resist = int'(PVECS[v].resist);
            prog_addr = PVECS[v].addr; prog_data = PVECS[v].data; prog_start = 1'b1;
            @(negedge clk);
            prog_start = 1'b0;
            check_eq("R9 busy after start", int'(busy), 1);
            wait_end(gd, gf);
            check_eq("R3 fail flag", int'(gf), int'(PVECS[v].exp_fail));
            check_eq("R3 done flag", int'(gd), int'(!PVECS[v].exp_fail));
            if (PVECS[v].exp_fail) check_eq("R3 fail_addr", int'(fail_addr), int'(PVECS[v].addr));
            else check_eq("R1 stored byte", int'(mem[PVECS[v].addr]), int'(PVECS[v].data));
            n = 0;
            for (int k = 0; k < lg_n; k++) if (is_pdata(k)) n++;
            check_eq("R3 attempts", n, int'(PVECS[v].exp_tries));
            check_eq("R1 op0 setup", int'(lg_we[0] && lg_dat[0] == 8'h40), 1);
            check_eq("R1 op1 data", int'(lg_we[1] && lg_addr[1] == PVECS[v].addr && lg_dat[1] == PVECS[v].data), 1);
            check_eq("R1 op2 verify cmd", int'(lg_we[2] && lg_dat[2] == 8'hC0), 1);
            check_eq("R1 op3 read", int'(!lg_we[3] && lg_addr[3] == PVECS[v].addr), 1);
            check_eq("R8 last op", int'(lg_we[lg_n-1] && lg_dat[lg_n-1] == 8'h00), 1);
            for (int k = 0; k + 1 < lg_n; k++)
                if (is_pdata(k) && (lg_req[k+1] - lg_ack[k] < PP))
                    check_eq("R2 pulse gap", lg_req[k+1] - lg_ack[k], PP);
            check_eq("R9 busy low at end", int'(busy), 0);
        end

        // Erase with one slow byte (R4, R5, R6, R8).
        prep(1);
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 37 + 1);
        weak_addr = 4; weak_left = 2;
        erase_start = 1'b1; @(negedge clk); erase_start = 1'b0;
        wait_end(gd, gf);
        check_eq("R5 erase done", int'(gd), 1);
        check_eq("R4 all zero before erase", pre_ok, 1);
        check_eq("R6 erase pulses", erase_pulses, 3);
        check_eq("R5 verify commands", count_cmd(8'hA0), DEPTH + 2);
        n = 0; for (int i = 0; i < DEPTH; i++) if (mem[i] == 8'hFF) n++;
        check_eq("R5 array blank", n, DEPTH);
        ordered = 1; first_pd = 0;
        for (int k = 0; k < lg_n; k++)
            if (is_pdata(k) && (k < 4 || lg_addr[k] != lg_addr[k-4])) begin
                if (int'(lg_addr[k]) != first_pd) ordered = 0;
                first_pd++;
            end
        check_eq("R4 preprogram order", ordered, 1);
        check_eq("R4 preprogram count", first_pd, DEPTH);
        pulse_idx = 0; first_a0_after = 0;
        for (int k = 1; k < lg_n; k++) begin
            if (lg_we[k] && lg_dat[k] == 8'h20 && lg_we[k-1] && lg_dat[k-1] == 8'h20 && pulse_idx < 3) begin
                check_eq("R5 erase pulse gap", int'(lg_req[k+1] - lg_ack[k] >= EP), 1);
                first_a0_after = 1;
                pulse_idx++;
            end else if (first_a0_after == 1 && lg_we[k] && lg_dat[k] == 8'hA0) begin
                resume_addr[pulse_idx-1] = int'(lg_addr[k]);
                first_a0_after = 0;
            end
        end
        check_eq("R6 first verify addr", resume_addr[0], 0);
        check_eq("R6 resume addr 2", resume_addr[1], 4);
        check_eq("R6 resume addr 3", resume_addr[2], 4);
        check_eq("R8 erase last op", int'(lg_we[lg_n-1] && lg_dat[lg_n-1] == 8'h00), 1);

        // Erase that never clears one byte (R7).
        prep(0);
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'h5A;
        weak_addr = 6; weak_left = 10;
        erase_start = 1'b1; @(negedge clk); erase_start = 1'b0;
        wait_end(gd, gf);
        check_eq("R7 erase fail", int'(gf), 1);
        check_eq("R7 fail_addr", int'(fail_addr), 6);
        check_eq("R7 erase pulses", erase_pulses, ET);
        check_eq("R8 fail last op", int'(lg_we[lg_n-1] && lg_dat[lg_n-1] == 8'h00), 1);

        // Start while busy is ignored (R9).
        prep(0);
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
        prog_addr = 3'd1; prog_data = 8'h55; prog_start = 1'b1;
        @(negedge clk); prog_start = 1'b0;
        repeat (3) @(negedge clk);
        erase_start = 1'b1; @(negedge clk); erase_start = 1'b0;
        wait_end(gd, gf);
        repeat (30) @(negedge clk);
        check_eq("R9 no erase while busy", count_cmd(8'h20), 0);
        check_eq("R9 single done", done_cnt, 1);
        check_eq("R9 still idle", int'(busy), 0);

        // Both starts together: program wins (R12).
        prep(2);
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
        prog_addr = 3'd6; prog_data = 8'h12; prog_start = 1'b1; erase_start = 1'b1;
        @(negedge clk); prog_start = 1'b0; erase_start = 1'b0;
        wait_end(gd, gf);
        check_eq("R12 program ran", int'(mem[6]), 8'h12);
        check_eq("R12 no erase", count_cmd(8'h20), 0);

        // Request fields held while waiting for acknowledge (R10).
        check_eq("R10 hold errors", hold_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule